// File: doc/BRIEF.md
# Retention Register Bank with Isolation Clamp

This block models a bank of retention flip-flops that sit in a power-switchable domain and feed an always-on consumer. A volatile main register captures data on the clock while the domain is powered. When the domain loses power, the main register is corrupted. A shadow copy on the always-on side is filled by a save strobe before power-down and holds its value through the off period. After power returns, a restore strobe copies it back into the main register.

The output toward the always-on side passes through an isolation stage. While the active-low isolation enable is asserted, the output is forced to a constant. A parameter picks this constant for each instance: all zeros (AND style) or all ones (OR style). The order of save, power-off, isolation, power-on and restore is set by an external controller. The block only flags save or restore strobes that arrive while the domain is unpowered.

Top module: `ret_clamp_bank`

## Requirements
- R1: A save strobe (`save_stb`=1) sampled with `pwr_good`=1 copies the main register into the shadow copy at that clock edge.
- R2: With `pwr_good`=1, `restore_stb`=0 and `wr_en`=1, the main register takes `d_in` at the clock edge. With `wr_en`=0 it holds its value.
- R3: A restore strobe sampled with `pwr_good`=1 loads the shadow value into the main register. In that cycle it takes priority over capture of `d_in`.
- R4: At each clock edge with `pwr_good`=0, the main register is set to all-X. The domain reset `dom_rst_n` (active low, asynchronous) sets the main register to `RESET_VAL`.
- R5: The shadow copy changes only on a powered save. It keeps its value while the domain is off and through any domain reset. Only the always-on reset `aon_rst_n` (active low, asynchronous) sets it to `RESET_VAL`.
- R6: A save or restore strobe sampled with `pwr_good`=0 changes neither register. It sets `seq_err` to 1 for exactly the following cycle. Otherwise `seq_err` is 0.
- R7: While `iso_n`=0, every bit of `q_out` equals `CLAMP_ONE` (0 for AND style, 1 for OR style). While `iso_n`=1, `q_out` equals the main register.
- R8: A save and a restore sampled in the same powered cycle exchange the two registers: the shadow copy takes the old main value and the main register takes the old shadow value.
- R9: After the always-on reset is released, `seq_err` is 0 and the shadow copy holds `RESET_VAL`. After the domain reset, `q_out` (with `iso_n`=1) shows `RESET_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, always-on |
| aon_rst_n | input | 1 | Always-on reset, active low, resets shadow and error flag |
| dom_rst_n | input | 1 | Switchable-domain reset, active low, resets main register |
| pwr_good | input | 1 | 1 while the switchable domain is powered |
| wr_en | input | 1 | Capture enable for the main register |
| d_in | input | WIDTH | Data captured into the main register |
| save_stb | input | 1 | Copy main register into shadow |
| restore_stb | input | 1 | Copy shadow into main register |
| iso_n | input | 1 | Isolation enable, active low |
| q_out | output | WIDTH | Isolated register output to the always-on side |
| seq_err | output | 1 | One-cycle flag for a strobe seen while unpowered |

## Verification
The hardest case to reach is one where a saved word survives a full power cycle. That cycle includes corruption of the main register, strobes rejected while the domain is off, and a domain reset after power-up. The word must then come back only through the restore path. The stimulus saves a distinctive value and removes power with isolation applied. It issues both strobe kinds while the domain is off, then brings power back and pulses the domain reset before restoring. The restored word can only have come from the shadow copy, because the main register has meanwhile been corrupted and then reset to a different value. A second instance with the opposite clamp polarity shares the same stimulus, so both clamp styles are seen in the isolated cycles.

// File: rtl/ret_bank_pkg.sv
package ret_bank_pkg;

  // Source selected for the next value of the main register.
  typedef enum logic [1:0] {
    MSEL_HOLD    = 2'd0,
    MSEL_CAPTURE = 2'd1,
    MSEL_RESTORE = 2'd2,
    MSEL_CORRUPT = 2'd3
  } main_sel_e;

  // Priority: power loss, then restore, then capture, then hold.
  function automatic main_sel_e pick_main_sel(input logic powered,
                                              input logic restore,
                                              input logic capture);
    main_sel_e sel;
    if (!powered)      sel = MSEL_CORRUPT;
    else if (restore)  sel = MSEL_RESTORE;
    else if (capture)  sel = MSEL_CAPTURE;
    else               sel = MSEL_HOLD;
    return sel;
  endfunction

  // A strobe that arrives while the domain is off is a sequencing error.
  function automatic logic strobe_misuse(input logic powered,
                                         input logic save,
                                         input logic restore);
    return (save | restore) & ~powered;
  endfunction

  // A strobe takes effect only while the domain is powered.
  function automatic logic strobe_effective(input logic powered,
                                            input logic strobe);
    return strobe & powered;
  endfunction

endpackage

// File: rtl/ret_main_reg.sv
module ret_main_reg
  import ret_bank_pkg::*;
#(
  parameter int unsigned       WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             dom_rst_n,
  input  logic             pwr_good,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] d_in,
  input  logic             restore_stb,
  input  logic [WIDTH-1:0] shadow_q,
  output logic [WIDTH-1:0] main_q,
  output logic             restore_ev
);

  main_sel_e        sel;
  logic [WIDTH-1:0] main_d;

  assign restore_ev = strobe_effective(pwr_good, restore_stb);
  assign sel        = pick_main_sel(pwr_good, restore_stb, wr_en);

  always_comb begin
    unique case (sel)
      MSEL_CORRUPT: main_d = 'x;
      MSEL_RESTORE: main_d = shadow_q;
      MSEL_CAPTURE: main_d = d_in;
      default:      main_d = main_q;
    endcase
  end

  always_ff @(posedge clk or negedge dom_rst_n) begin
    if (!dom_rst_n) main_q <= RESET_VAL;
    else            main_q <= main_d;
  end

  AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!dom_rst_n)
    restore_ev |=> main_q == $past(shadow_q)); // R3

  AST_CAPTURE_DATA: assert property (@(posedge clk) disable iff (!dom_rst_n)
    (pwr_good && wr_en && !restore_stb) |=> main_q == $past(d_in)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!dom_rst_n)
    (pwr_good && !wr_en && !restore_stb) |=> $stable(main_q)); // R2

endmodule

// File: rtl/ret_shadow_latch.sv
module ret_shadow_latch #(
  parameter int unsigned       WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             aon_rst_n,
  input  logic             save_ev,
  input  logic [WIDTH-1:0] main_q,
  output logic [WIDTH-1:0] shadow_q
);

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n)   shadow_q <= RESET_VAL;
    else if (save_ev) shadow_q <= main_q;
  end

  AST_SAVE_COPIES: assert property (@(posedge clk) disable iff (!aon_rst_n)
    save_ev |=> shadow_q == $past(main_q)); // R1

  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !save_ev |=> $stable(shadow_q)); // R5

endmodule

// File: rtl/ret_iso_clamp.sv
module ret_iso_clamp #(
  parameter int unsigned WIDTH     = 8,
  parameter bit          CLAMP_ONE = 1'b0
) (
  input  logic             iso_n,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out
);

  localparam logic [WIDTH-1:0] CLAMP_WORD = {WIDTH{CLAMP_ONE}};

  generate
    if (CLAMP_ONE) begin : g_or_style
      assign data_out = data_in | {WIDTH{~iso_n}};
    end else begin : g_and_style
      assign data_out = data_in & {WIDTH{iso_n}};
    end
  endgenerate

  always_comb begin
    if (!iso_n) begin
      AST_CLAMP_CONST: assert (data_out == CLAMP_WORD); // R7
    end
  end

endmodule

// File: rtl/ret_clamp_bank.sv
module ret_clamp_bank
  import ret_bank_pkg::*;
#(
  parameter int unsigned       WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0,
  parameter bit                CLAMP_ONE = 1'b0
) (
  input  logic             clk,
  input  logic             aon_rst_n,
  input  logic             dom_rst_n,
  input  logic             pwr_good,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] d_in,
  input  logic             save_stb,
  input  logic             restore_stb,
  input  logic             iso_n,
  output logic [WIDTH-1:0] q_out,
  output logic             seq_err
);

  logic [WIDTH-1:0] main_q;
  logic [WIDTH-1:0] shadow_q;
  logic             save_ev;
  logic             restore_ev;
  logic             misuse_ev;

  assign save_ev   = strobe_effective(pwr_good, save_stb);
  assign misuse_ev = strobe_misuse(pwr_good, save_stb, restore_stb);

  ret_main_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_main (
    .clk         (clk),
    .dom_rst_n   (dom_rst_n),
    .pwr_good    (pwr_good),
    .wr_en       (wr_en),
    .d_in        (d_in),
    .restore_stb (restore_stb),
    .shadow_q    (shadow_q),
    .main_q      (main_q),
    .restore_ev  (restore_ev)
  );

  ret_shadow_latch #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_shadow (
    .clk       (clk),
    .aon_rst_n (aon_rst_n),
    .save_ev   (save_ev),
    .main_q    (main_q),
    .shadow_q  (shadow_q)
  );

  ret_iso_clamp #(.WIDTH(WIDTH), .CLAMP_ONE(CLAMP_ONE)) u_clamp (
    .iso_n    (iso_n),
    .data_in  (main_q),
    .data_out (q_out)
  );

  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n) seq_err <= 1'b0;
    else            seq_err <= misuse_ev;
  end

  AST_ERR_ON_MISUSE: assert property (@(posedge clk) disable iff (!aon_rst_n)
    ((save_stb || restore_stb) && !pwr_good) |=> seq_err); // R6

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !((save_stb || restore_stb) && !pwr_good) |=> !seq_err); // R6

  AST_OFF_SAVE_IGNORED: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !pwr_good |=> $stable(shadow_q)); // R6

  AST_OFF_NO_RESTORE: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !pwr_good |-> !restore_ev); // R6

  AST_ISO_OUTPUT: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !iso_n |-> q_out == {WIDTH{CLAMP_ONE}}); // R7

  AST_SWAP: assert property (@(posedge clk) disable iff (!aon_rst_n || !dom_rst_n)
    (save_ev && restore_ev) |=> shadow_q == $past(main_q) && main_q == $past(shadow_q)); // R8

endmodule

// File: tb/test_ret_clamp_bank.sv
`timescale 1ns/1ps
module test_ret_clamp_bank;

  localparam int unsigned W  = 8;
  localparam logic [W-1:0] RV = 8'h5A;

  logic         clk = 1'b0;
  logic         aon_rst_n, dom_rst_n, pwr_good, wr_en, save_stb, restore_stb, iso_n;
  logic [W-1:0] d_in;
  logic [W-1:0] q_and, q_or;
  logic         err_and, err_or;

  always #2 clk = ~clk;  // 250 MHz

  ret_clamp_bank #(.WIDTH(W), .RESET_VAL(RV), .CLAMP_ONE(1'b0)) i_ret_clamp_bank (
    .clk(clk), .aon_rst_n(aon_rst_n), .dom_rst_n(dom_rst_n), .pwr_good(pwr_good),
    .wr_en(wr_en), .d_in(d_in), .save_stb(save_stb), .restore_stb(restore_stb),
    .iso_n(iso_n), .q_out(q_and), .seq_err(err_and));

  ret_clamp_bank #(.WIDTH(W), .RESET_VAL(RV), .CLAMP_ONE(1'b1)) i_ret_clamp_bank_or (
    .clk(clk), .aon_rst_n(aon_rst_n), .dom_rst_n(dom_rst_n), .pwr_good(pwr_good),
    .wr_en(wr_en), .d_in(d_in), .save_stb(save_stb), .restore_stb(restore_stb),
    .iso_n(iso_n), .q_out(q_or), .seq_err(err_or));

  typedef struct {
    logic [W-1:0] q0;
    logic [W-1:0] q1;
    bit           chk_q;
    logic         err;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Reference state built from the requirements.
  logic [W-1:0] m_main, m_shadow;
  bit           m_valid;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected outputs after the edge.
  task automatic cyc(input logic wr, input logic [W-1:0] d, input logic sv, input logic rs,
                     input logic iso, input logic pg, input logic drst, input logic arst,
                     input string tag);
    exp_t         e;
    logic [W-1:0] nm, ns;
    bit           nv;
    @(negedge clk);
    wr_en = wr; d_in = d; save_stb = sv; restore_stb = rs;
    iso_n = iso; pwr_good = pg; dom_rst_n = drst; aon_rst_n = arst;
    nm = m_main; nv = m_valid; ns = m_shadow;
    if (!drst)    begin nm = RV; nv = 1; end
    else if (!pg) nv = 0;
    else if (rs)  begin nm = m_shadow; nv = 1; end
    else if (wr)  begin nm = d; nv = 1; end
    if (!arst)         ns = RV;
    else if (sv && pg) ns = m_main;
    m_main = nm; m_valid = nv; m_shadow = ns;
    e.tag   = tag;
    e.err   = arst && (sv || rs) && !pg;
    e.chk_q = !iso || nv;
    e.q0    = iso ? nm : '0;
    e.q1    = iso ? nm : '1;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  // Monitor: compare after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.chk_q) begin
          check({e.tag, " q_and"}, q_and, e.q0);
          check({e.tag, " q_or"},  q_or,  e.q1);
        end
        check({e.tag, " err"}, {7'b0, err_and}, {7'b0, e.err});
        check({e.tag, " err_or"}, {7'b0, err_or}, {7'b0, e.err});
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    aon_rst_n = 0; dom_rst_n = 0; pwr_good = 1; wr_en = 0; d_in = '0;
    save_stb = 0; restore_stb = 0; iso_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    aon_rst_n = 1; dom_rst_n = 1;
    #1;
    check("R9 reset q", q_and, RV);
    check("R9 reset err", {7'b0, err_and}, 8'h00);
    m_main = RV; m_shadow = RV; m_valid = 1;

    // R2 capture and hold
    cyc(1, 8'h11, 0, 0, 1, 1, 1, 1, "R2 capture");
    cyc(0, 8'h22, 0, 0, 1, 1, 1, 1, "R2 hold");
    cyc(1, 8'h33, 0, 0, 1, 1, 1, 1, "R2 capture2");
    // R1 save, then overwrite main
    cyc(0, 8'h00, 1, 0, 1, 1, 1, 1, "R1 save");
    cyc(1, 8'h44, 0, 0, 1, 1, 1, 1, "R2 overwrite");
    // R3 restore wins over capture
    cyc(1, 8'h99, 0, 1, 1, 1, 1, 1, "R3 restore priority");
    cyc(1, 8'hC6, 0, 0, 1, 1, 1, 1, "R2 capture3");
    cyc(0, 8'h00, 1, 0, 1, 1, 1, 1, "R1 save2");
    cyc(1, 8'h77, 0, 0, 1, 1, 1, 1, "R2 capture4");
    // R7 isolation while powered
    cyc(0, 8'h00, 0, 0, 0, 1, 1, 1, "R7 clamp powered");
    cyc(0, 8'h00, 0, 0, 1, 1, 1, 1, "R7 pass through");
    // Power down under isolation, strobes rejected
    cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, "R4 power off clamp");
    cyc(1, 8'hEE, 1, 0, 0, 0, 1, 1, "R6 save while off");
    cyc(0, 8'h00, 0, 1, 0, 0, 1, 1, "R6 restore while off");
    cyc(0, 8'h00, 0, 0, 0, 0, 1, 1, "R6 flag clears");
    // Power back, domain reset, then restore
    cyc(0, 8'h00, 0, 0, 0, 1, 0, 1, "R4 domain reset iso");
    cyc(0, 8'h00, 0, 0, 1, 1, 1, 1, "R4 reset value");
    cyc(0, 8'h00, 0, 1, 1, 1, 1, 1, "R5 restore after power cycle");
    // R8 swap
    cyc(1, 8'h12, 0, 0, 1, 1, 1, 1, "R2 capture5");
    cyc(0, 8'h00, 1, 1, 1, 1, 1, 1, "R8 swap");
    cyc(0, 8'h00, 0, 1, 1, 1, 1, 1, "R8 swapped shadow");
    // R5 always-on reset clears shadow only
    cyc(1, 8'h3C, 0, 0, 1, 1, 1, 0, "R5 aon reset");
    cyc(0, 8'h00, 0, 1, 1, 1, 1, 1, "R5 restore reset shadow");
    cyc(0, 8'h00, 0, 0, 1, 1, 1, 1, "R9 idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule